// File: doc/BRIEF.md
# H-Bridge Chopper Control

This block is the digital controller of a full-bridge motor driver. It turns a direction input, an external PWM gate input, an external decay select, a current-sense trip and two supply-fault flags into four gate enables: high and low switch of leg A and leg B. All inputs are asynchronous to the system clock and pass through a two-stage synchronizer before use.

When the sensed current trips, a source-enable latch drops and a fixed off-time timer starts. The timer counts ticks of an oscillator pulse input. During the off time the winding recirculates along a path set by an internal decay select: slow, fast, or mixed. Mixed decay runs fast for the first quarter of the interval and slow for the rest. Each leg has a small state register that puts in a one-clock all-off gap whenever it swaps between its high and low switch. A regulator fault blanks every output. A charge-pump fault blanks only the high switches.

Top module: `hb_chopper_ctrl`

## Requirements
- R1: While reset is asserted, all four gate enables are 0.
- R2: With the PWM input high and no off time running, direction 1 drives high A and low B, and direction 0 drives high B and low A.
- R3: With the PWM input low and the external decay select low (fast), the bridge drives the diagonal opposite to the one the direction selects.
- R4: With the PWM input low and the external decay select high (slow), both low switches are on and both high switches are off.
- R5: A trip while the latch is set starts an off time. The selected high switch turns off and the path follows the internal decay select: 2'b00 or 2'b11 slow (both low on), 2'b01 fast (opposite diagonal), 2'b10 mixed.
- R6: The off time ends on exactly the 96th oscillator tick after the trip. The selected pair then turns back on.
- R7: Trips that arrive during an off time have no effect on its length or on the outputs.
- R8: In mixed decay, the first 24 ticks of the off time use the fast path and the remaining ticks use the slow path.
- R9: The high and low switch of one leg are never on together. A leg going from high to low or from low to high spends exactly one clock with both switches off.
- R10: A regulator fault forces all four gate enables to 0.
- R11: A charge-pump fault forces both high switches to 0 and leaves the low switches as they would otherwise be.
- R12: A change on an input pin reaches the outputs on the third rising clock edge. When a leg must reverse, it reaches that leg on the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Bridge direction (1: A high, B low) |
| pwm_i | input | 1 | External PWM gate; high turns on the selected pair |
| ext_slow_i | input | 1 | Recirculation with PWM low: 1 slow, 0 fast |
| trip_i | input | 1 | Current-sense comparator trip |
| osc_tick_i | input | 1 | One-clock pulse per internal oscillator period |
| decay_sel_i | input | 2 | Off-time decay: 00 slow, 01 fast, 10 mixed, 11 slow |
| vreg_fault_i | input | 1 | Regulator supply fault |
| pump_fault_i | input | 1 | Charge-pump supply fault |
| hi_a_o | output | 1 | Leg A high-side enable |
| lo_a_o | output | 1 | Leg A low-side enable |
| hi_b_o | output | 1 | Leg B high-side enable |
| lo_b_o | output | 1 | Leg B low-side enable |

## Verification
A pin change takes two synchronizer edges and one leg-register edge, so a simple result is visible after the third rising edge. A reversing leg shows all-off after the third edge and its new state after the fourth. The bench drives pins on falling edges and checks the dead gap and the three-edge latency cycle by cycle at those exact falling edges. Other checks wait six clocks for the result to settle. Off-time lengths are counted in ticks that the bench issues one at a time, spaced four clocks apart. The outputs are checked one tick before and on the tick where each decay phase or the off time is due to end.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10,
    DK_SLOW2 = 2'b11
  } decay_e;

  localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hb_offtimer.sv
module hb_offtimer #(
  parameter int unsigned OFF_TICKS = 96,
  parameter int unsigned CNT_W     = $clog2(OFF_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_i,
  input  logic             tick_i,
  output logic             src_en_o,
  output logic             fast_win_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] MIX_CNT  = CNT_W'(OFF_TICKS / 4);

  logic             src_en_q, src_en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // Counter advances only on an oscillator tick while the latch is clear.
  assign cnt_ce = !src_en_q && tick_i;

  always_comb begin
    src_en_d = src_en_q;
    cnt_d    = cnt_q;
    if (src_en_q) begin
      if (trip_i) begin
        src_en_d = 1'b0;
        cnt_d    = '0;
      end
    end else if (cnt_ce) begin
      if (cnt_q == LAST_CNT) begin
        src_en_d = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      src_en_q <= src_en_d;
      cnt_q    <= cnt_d;
    end
  end

  assign src_en_o   = src_en_q;
  assign fast_win_o = (cnt_q < MIX_CNT);
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  leg_e tgt_i,
  output logic hi_o,
  output logic lo_o
);

  leg_e cur_q, cur_d;

  // A swap between the two switches passes through OFF for one clock.
  always_comb begin
    if (cur_q != LEG_OFF && tgt_i != cur_q) cur_d = LEG_OFF;
    else                                    cur_d = tgt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= LEG_OFF;
    else        cur_q <= cur_d;
  end

  assign hi_o = (cur_q == LEG_HI);
  assign lo_o = (cur_q == LEG_LO);

endmodule

// File: rtl/hb_chopper_ctrl.sv
module hb_chopper_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OFF_TICKS   = 96,
  parameter int unsigned CNT_W       = $clog2(OFF_TICKS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_i,
  input  logic       pwm_i,
  input  logic       ext_slow_i,
  input  logic       trip_i,
  input  logic       osc_tick_i,
  input  logic [1:0] decay_sel_i,
  input  logic       vreg_fault_i,
  input  logic       pump_fault_i,
  output logic       hi_a_o,
  output logic       lo_a_o,
  output logic       hi_b_o,
  output logic       lo_b_o
);

  localparam int unsigned IN_W = 9;

  logic [IN_W-1:0]  raw_in, syn_in;
  logic             dir_s, pwm_s, ext_slow_s, trip_s, tick_s;
  logic             reg_fault_s, cp_fault_s;
  decay_e           decay_s;
  logic             src_en, fast_win;
  logic [CNT_W-1:0] off_cnt;
  logic             use_fast, int_fast;
  leg_e             sel_leg [NUM_LEGS];
  leg_e             opp_leg [NUM_LEGS];
  leg_e             tgt_leg [NUM_LEGS];
  logic [NUM_LEGS-1:0] hi_v, lo_v;

  assign raw_in = {dir_i, pwm_i, ext_slow_i, trip_i, osc_tick_i,
                   decay_sel_i, vreg_fault_i, pump_fault_i};

  hb_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign dir_s       = syn_in[8];
  assign pwm_s       = syn_in[7];
  assign ext_slow_s  = syn_in[6];
  assign trip_s      = syn_in[5];
  assign tick_s      = syn_in[4];
  assign decay_s     = decay_e'(syn_in[3:2]);
  assign reg_fault_s = syn_in[1];
  assign cp_fault_s  = syn_in[0];

  hb_offtimer #(.OFF_TICKS(OFF_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (trip_s),
    .tick_i     (tick_s),
    .src_en_o   (src_en),
    .fast_win_o (fast_win),
    .cnt_o      (off_cnt)
  );

  // Internal chop recirculation path.
  always_comb begin
    case (decay_s)
      DK_FAST:  int_fast = 1'b1;
      DK_MIXED: int_fast = fast_win;
      default:  int_fast = 1'b0;
    endcase
  end

  // Per-leg target state: index 0 is leg A, index 1 is leg B.
  always_comb begin
    sel_leg[0] = dir_s ? LEG_HI : LEG_LO;
    sel_leg[1] = dir_s ? LEG_LO : LEG_HI;
    opp_leg[0] = dir_s ? LEG_LO : LEG_HI;
    opp_leg[1] = dir_s ? LEG_HI : LEG_LO;
    use_fast   = pwm_s ? int_fast : !ext_slow_s;
    for (int i = 0; i < NUM_LEGS; i++) begin
      if (pwm_s && src_en)  tgt_leg[i] = sel_leg[i];
      else if (use_fast)    tgt_leg[i] = opp_leg[i];
      else                  tgt_leg[i] = LEG_LO;
      if (cp_fault_s && tgt_leg[i] == LEG_HI) tgt_leg[i] = LEG_OFF;
      if (reg_fault_s)                        tgt_leg[i] = LEG_OFF;
    end
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .tgt_i (tgt_leg[g]),
      .hi_o  (hi_v[g]),
      .lo_o  (lo_v[g])
    );
  end

  assign hi_a_o = hi_v[0];
  assign lo_a_o = lo_v[0];
  assign hi_b_o = hi_v[1];
  assign lo_b_o = lo_v[1];

endmodule

// File: rtl/hb_chopper_chk.sv
module hb_chopper_chk #(
  parameter int unsigned OFF_TICKS = 96,
  parameter int unsigned CNT_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hi_a_o,
  input logic             lo_a_o,
  input logic             hi_b_o,
  input logic             lo_b_o,
  input logic             reg_fault_s,
  input logic             cp_fault_s,
  input logic             tick_s,
  input logic             src_en,
  input logic [CNT_W-1:0] off_cnt
);

  p_excl_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_a_o && lo_a_o));
  p_excl_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_b_o && lo_b_o));
  p_dead_ahl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_a_o |=> !lo_a_o);
  p_dead_alh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_a_o |=> !hi_a_o);
  p_dead_bhl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_b_o |=> !lo_b_o);
  p_dead_blh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_b_o |=> !hi_b_o);
  p_vreg_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fault_s |=> !(hi_a_o || lo_a_o || hi_b_o || lo_b_o));
  p_pump_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault_s |=> !(hi_a_o || hi_b_o));
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    off_cnt < CNT_W'(OFF_TICKS));
  p_rearm_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_en) |-> $past(tick_s));

endmodule

bind hb_chopper_ctrl hb_chopper_chk #(.OFF_TICKS(OFF_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hi_a_o      (hi_a_o),
  .lo_a_o      (lo_a_o),
  .hi_b_o      (hi_b_o),
  .lo_b_o      (lo_b_o),
  .reg_fault_s (reg_fault_s),
  .cp_fault_s  (cp_fault_s),
  .tick_s      (tick_s),
  .src_en      (src_en),
  .off_cnt     (off_cnt)
);

// File: tb/hb_chopper_ctrl_tb.sv
`timescale 1ns/1ps
module hb_chopper_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_i, pwm_i, ext_slow_i, trip_i, osc_tick_i;
  logic [1:0] decay_sel_i;
  logic       vreg_fault_i, pump_fault_i;
  logic       hi_a_o, lo_a_o, hi_b_o, lo_b_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hb_chopper_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_i        (dir_i),
    .pwm_i        (pwm_i),
    .ext_slow_i   (ext_slow_i),
    .trip_i       (trip_i),
    .osc_tick_i   (osc_tick_i),
    .decay_sel_i  (decay_sel_i),
    .vreg_fault_i (vreg_fault_i),
    .pump_fault_i (pump_fault_i),
    .hi_a_o       (hi_a_o),
    .lo_a_o       (lo_a_o),
    .hi_b_o       (hi_b_o),
    .lo_b_o       (lo_b_o)
  );

  // Expected order: {hi_a, lo_a, hi_b, lo_b}
  task automatic expect_out(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {hi_a_o, lo_a_o, hi_b_o, lo_b_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick_i = 1'b1;
      @(negedge clk);
      osc_tick_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_trip();
    trip_i = 1'b1;
    repeat (2) @(negedge clk);
    trip_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; dir_i = 1'b1; pwm_i = 1'b1; ext_slow_i = 1'b0;
    trip_i = 1'b0; osc_tick_i = 1'b0; decay_sel_i = 2'b00;
    vreg_fault_i = 1'b0; pump_fault_i = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R1 reset", 4'b0000);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_drive();
    pwm_i = 1'b1; dir_i = 1'b1; settle();
    expect_out("R2 dir1 on", 4'b1001);
    dir_i = 1'b0;
    repeat (2) @(negedge clk);
    expect_out("R12 not yet after 2 edges", 4'b1001);
    @(negedge clk);
    expect_out("R9 dead gap on reversal", 4'b0000);
    @(negedge clk);
    expect_out("R12 reversal on 4th edge", 4'b0110);
    settle();
    expect_out("R2 dir0 on", 4'b0110);
  endtask

  task automatic t_ext_decay();
    pwm_i = 1'b0; ext_slow_i = 1'b0; dir_i = 1'b1; settle();
    expect_out("R3 fast dir1", 4'b0110);
    dir_i = 1'b0; settle();
    expect_out("R3 fast dir0", 4'b1001);
    ext_slow_i = 1'b1; settle();
    expect_out("R4 slow dir0", 4'b0101);
    dir_i = 1'b1; settle();
    expect_out("R4 slow dir1", 4'b0101);
  endtask

  task automatic t_trip_slow();
    decay_sel_i = 2'b00; pwm_i = 1'b1; dir_i = 1'b1; settle();
    expect_out("R2 before trip", 4'b1001);
    pulse_trip(); settle();
    expect_out("R5 slow path", 4'b0101);
    ticks(95); settle();
    expect_out("R6 still off after 95", 4'b0101);
    ticks(1); settle();
    expect_out("R6 on after 96", 4'b1001);
  endtask

  task automatic t_trip_fast();
    decay_sel_i = 2'b01; dir_i = 1'b0; settle();
    expect_out("R2 dir0 before trip", 4'b0110);
    pulse_trip(); settle();
    expect_out("R5 fast path", 4'b1001);
    ticks(95); settle();
    expect_out("R6 fast still off", 4'b1001);
    ticks(1); settle();
    expect_out("R6 fast restored", 4'b0110);
  endtask

  task automatic t_mixed();
    decay_sel_i = 2'b10; dir_i = 1'b1; settle();
    pulse_trip(); settle();
    expect_out("R8 mixed fast start", 4'b0110);
    ticks(23); settle();
    expect_out("R8 fast through tick 23", 4'b0110);
    ticks(1); settle();
    expect_out("R8 slow from tick 24", 4'b0101);
    ticks(71); settle();
    expect_out("R8 slow at tick 95", 4'b0101);
    ticks(1); settle();
    expect_out("R6 mixed restored", 4'b1001);
  endtask

  task automatic t_retrip();
    decay_sel_i = 2'b11; dir_i = 1'b1; settle();
    pulse_trip(); settle();
    ticks(10);
    pulse_trip(); settle();
    expect_out("R7 retrip no change", 4'b0101);
    ticks(85); settle();
    expect_out("R7 length kept at 95", 4'b0101);
    ticks(1); settle();
    expect_out("R7 restored at 96", 4'b1001);
  endtask

  task automatic t_faults();
    pwm_i = 1'b1; dir_i = 1'b1; pump_fault_i = 1'b1; settle();
    expect_out("R11 pump fault drive", 4'b0001);
    pwm_i = 1'b0; ext_slow_i = 1'b0; settle();
    expect_out("R11 pump fault fast decay", 4'b0100);
    pump_fault_i = 1'b0; pwm_i = 1'b1; settle();
    expect_out("R11 pump fault cleared", 4'b1001);
    vreg_fault_i = 1'b1; settle();
    expect_out("R10 vreg fault", 4'b0000);
    vreg_fault_i = 1'b0;
    repeat (2) @(negedge clk);
    expect_out("R12 release not yet", 4'b0000);
    @(negedge clk);
    expect_out("R12 release on 3rd edge", 4'b1001);
  endtask

  initial begin
    t_reset();
    t_drive();
    t_ext_decay();
    t_trip_slow();
    t_trip_fast();
    t_mixed();
    t_retrip();
    t_faults();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule